// File: doc/BRIEF.md
# Run-Time Programmable FIR Filter with Coefficient Shadowing

This block is a direct-form FIR filter whose tap weights are not fixed at build time. A host processor loads them through a small write port. Each write lands in a coefficient register file. A single commit strobe then copies the whole file into a shadow bank. Only the shadow bank feeds the multipliers. Because of this, the host can prepare a complete new response while samples keep flowing through the current one. One hardware filter can therefore serve several responses of equal length.

Samples and coefficients are signed fixed-point values, 14 bits each with 13 fractional bits. Every product is kept at its full 28-bit width. The products are summed without rounding into an accumulator that is wide enough for all taps. The output carries that accumulator's width and format and is registered once. The tap count is a parameter, and its default is 16.

Top module: `prog_fir`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `y_vld` is 0 and `y_out` is 0. Reset clears the delay line, the register file and the shadow bank to zero, so valid samples give a zero result until a coefficient set has been committed.
- R2: `y_vld` is 1 in exactly the cycle after a clock edge at which `smp_vld` was 1. `y_out` changes only on such edges and otherwise holds its last value.
- R3: For a valid sample x[n] taken at an edge, the next `y_out` equals the sum over k of c[k]·x[n-k]. Here c is the shadow bank before that edge, c[0] weights the newest sample, and x[n-k] is the k-th previous valid sample. The delay line advances only on valid samples.
- R4: Products and the sum are exact two's-complement values with no rounding or saturation. `y_out` is DW+CW+clog2(TAPS) bits wide (32 bits for the default). The all-most-negative case, where every tap is -8192 and every sample is -8192, gives TAPS·2^26.
- R5: At an edge where `cw_en` is 1 and `cw_addr` < TAPS, `cw_data` is stored in register-file entry `cw_addr`. Addresses from TAPS up to 2^AW-1 leave the file unchanged.
- R6: Register-file writes have no effect on `y_out` until a commit.
- R7: At an edge where `cw_commit` is 1, the whole shadow bank takes the register file's contents. A sample taken at that same edge still uses the previous shadow set, and later samples use the new one.
- R8: A register-file write at the same edge as a commit is not part of the transferred set. It becomes effective at the next commit.
- R9: Samples may be valid on every cycle while coefficients are being written. No sample is dropped or stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_in | input | DW | Signed input sample (Q1.13) |
| smp_vld | input | 1 | Sample valid |
| cw_addr | input | AW | Coefficient register-file address |
| cw_en | input | 1 | Coefficient write enable |
| cw_data | input | CW | Signed coefficient word (Q1.13) |
| cw_commit | input | 1 | Copy register file into shadow bank |
| y_out | output | ACCW | Full-precision filter output |
| y_vld | output | 1 | Output valid |

## Verification
The hardest situation to reach is the exact edge of a commit. At that edge a sample is being filtered, a write is landing in the register file, and the shadow bank is being replaced, all at once. The stimulus streams samples with no gaps. It writes a full set while filtering, and then asserts commit together with a write to entry 0 and a valid sample. This shows whether the sample used the old set and whether the late write waited for the following commit. A bench instance with 12 taps exposes unused addresses, so writes to addresses 12 to 15 can be shown to change nothing.

// File: rtl/prog_fir.sv
module prog_fir #(
  parameter int TAPS = 16,
  parameter int DW   = 14,
  parameter int CW   = 14,
  localparam int AW   = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int PW   = DW + CW,
  localparam int ACCW = PW + $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   smp_in,
  input  logic            smp_vld,
  input  logic [AW-1:0]   cw_addr,
  input  logic            cw_en,
  input  logic [CW-1:0]   cw_data,
  input  logic            cw_commit,
  output logic [ACCW-1:0] y_out,
  output logic            y_vld
);

  logic [TAPS-1:0][CW-1:0] rf;
  logic [TAPS-1:0][CW-1:0] shad;
  logic [TAPS-2:0][DW-1:0] dl;
  logic [TAPS-1:0][DW-1:0] win;
  logic [ACCW-1:0]         acc;

  assign win = {dl, smp_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf   <= '0;
      shad <= '0;
    end else begin
      if (cw_en && ({1'b0, cw_addr} < (AW+1)'(TAPS)))
        rf[cw_addr] <= cw_data;
      if (cw_commit)
        shad <= rf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl <= '0;
    end else if (smp_vld) begin
      dl[0] <= smp_in;
      for (int i = 1; i < TAPS-1; i++)
        dl[i] <= dl[i-1];
    end
  end

  always_comb begin
    logic signed [PW-1:0] p;
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      p   = $signed(shad[i]) * $signed(win[i]);
      acc = acc + {{(ACCW-PW){p[PW-1]}}, p};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= smp_vld;
      if (smp_vld)
        y_out <= acc;
    end
  end

endmodule

// File: rtl/prog_fir_chk.sv
module prog_fir_chk #(
  parameter int TAPS = 16,
  parameter int CW   = 14,
  parameter int ACCW = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic                    cw_commit,
  input logic [ACCW-1:0]         y_out,
  input logic                    y_vld,
  input logic [TAPS-1:0][CW-1:0] rf,
  input logic [TAPS-1:0][CW-1:0] shad
);

  p_rst_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!y_vld && y_out == '0));

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld == $past(smp_vld));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> $stable(y_out));

  p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cw_commit) |-> shad == $past(rf));

  p_shadow_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cw_commit) |-> $stable(shad));

endmodule

bind prog_fir prog_fir_chk #(.TAPS(TAPS), .CW(CW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cw_commit(cw_commit),
  .y_out(y_out), .y_vld(y_vld), .rf(rf), .shad(shad)
);

// File: tb/test_prog_fir.sv
`timescale 1ns/1ps
module test_prog_fir;
  localparam int NT   = 12;
  localparam int AW   = 4;
  localparam int ACCW = 14 + 14 + 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [13:0]     smp_in = '0;
  logic            smp_vld = 1'b0;
  logic [AW-1:0]   cw_addr = '0;
  logic            cw_en = 1'b0;
  logic [13:0]     cw_data = '0;
  logic            cw_commit = 1'b0;
  logic [ACCW-1:0] y_out;
  logic            y_vld;

  always #10 clk = ~clk;

  prog_fir #(.TAPS(NT)) i_prog_fir (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
    .cw_addr(cw_addr), .cw_en(cw_en), .cw_data(cw_data), .cw_commit(cw_commit),
    .y_out(y_out), .y_vld(y_vld)
  );

  int checks = 0, fails = 0;
  int rfm[NT];
  int shm[NT];
  int hist[$];
  logic [ACCW-1:0] exp_y = '0;
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd14();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[29:16]));
  endfunction

  task automatic chk(input string tag, input logic [ACCW-1:0] act, input logic [ACCW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  // one clock: inputs applied at negedge, outputs compared at next negedge
  task automatic cyc(input bit v, input int x, input bit we, input int a, input int d,
                     input bit cm, input string tag);
    longint s;
    int old_rf[NT];
    smp_vld = v; smp_in = 14'(x); cw_en = we; cw_addr = AW'(a);
    cw_data = 14'(d); cw_commit = cm;
    if (v) begin
      hist.push_front(x);
      while (hist.size() > NT) void'(hist.pop_back());
      s = 0;
      for (int k = 0; k < hist.size(); k++) s += longint'(shm[k]) * longint'(hist[k]);
      exp_y = ACCW'(s);
    end
    old_rf = rfm;
    if (we && a < NT) rfm[a] = d;
    if (cm) shm = old_rf;
    @(negedge clk);
    chk({tag, " vld (R2)"}, ACCW'(y_vld), ACCW'(v));
    chk({tag, " out"}, y_out, exp_y);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin rfm[i] = 0; shm[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset vld", ACCW'(y_vld), '0);
    chk("R1 reset out", y_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset vld", ACCW'(y_vld), '0);
    chk("R1 after reset out", y_out, '0);
    // zero coefficients: outputs stay zero
    for (int i = 0; i < 6; i++) cyc(1, rnd14(), 0, 0, 0, 0, "R1 zero shadow");
    // write set A while filtering; no commit yet (R6, R9, R5)
    for (int i = 0; i < NT; i++) cyc(1, rnd14(), 1, i, (i + 1) * 311 - 2000, 0, "R9 R6 write during filter");
    for (int a = NT; a < 16; a++) cyc(1, rnd14(), 1, a, 8191, 0, "R5 out of range write");
    // commit with simultaneous write to entry 0 (R7, R8)
    cyc(1, rnd14(), 1, 0, -5000, 1, "R7 R8 commit edge");
    for (int i = 0; i < 20; i++) cyc(1, rnd14(), 0, 0, 0, 0, "R3 set A");
    // gaps: output holds, delay line frozen (R2, R3)
    for (int i = 0; i < 10; i++) cyc(i % 3 == 0, rnd14(), 0, 0, 0, 0, "R2 R3 gapped");
    // impulse response with set A
    cyc(1, 8191, 0, 0, 0, 0, "R3 impulse");
    for (int i = 0; i < NT + 2; i++) cyc(1, 0, 0, 0, 0, 0, "R3 impulse tail");
    // second commit picks up pending entry-0 write (R8)
    cyc(0, 0, 0, 0, 0, 1, "R8 second commit");
    cyc(1, 8191, 0, 0, 0, 0, "R8 impulse tap0");
    cyc(1, 0, 0, 0, 0, 0, "R8 impulse tap1");
    // extreme values (R4)
    for (int i = 0; i < NT; i++) cyc(0, 0, 1, i, -8192, 0, "R4 load extremes");
    cyc(0, 0, 0, 0, 0, 1, "R4 commit extremes");
    for (int i = 0; i < NT + 2; i++) cyc(1, -8192, 0, 0, 0, 0, "R4 full precision");
    chk("R4 max magnitude", y_out, ACCW'(longint'(NT) * (longint'(1) << 26)));
    for (int i = 0; i < NT + 2; i++) cyc(1, 8191, 0, 0, 0, 0, "R4 opposite sign");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, "R2 idle hold");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule